// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Programmer

This block keeps the divider settings for one channel of a phase-locked frequency synthesizer and runs the counters that carry them out. A channel is programmed with a 10-bit main count N, a 6-bit swallow count A, a 3-bit reference-select code and a transmit/receive select. The swallow counter steers the modulus-control line of an external divide-by-64/65 prescaler. It asks for divide-by-65 during the first A prescaler periods of each output cycle and divide-by-64 for the rest. One divided output cycle therefore spans 64·N + A VCO periods. With a 5 kHz comparison step, for example, N = 457 and A = 20 give a division of 29268.

The reference divider turns reference-clock cycles into comparison pulses. The ratio comes from the select code, and one reserved code switches the channel off. The whole design runs on one system clock. `ref_en` marks a reference-clock cycle and `pre_en` marks one prescaler output period. New settings are captured on `load` and wait in a shadow copy. They are applied at the next division boundary, so a running cycle is never cut short.

Top module: `pll_swallow_prog`

## Requirements
- R1: In each divided cycle `mod_ctl` is 1 (divide-by-65) for the first A `pre_en` steps and 0 (divide-by-64) for the remaining N−A steps, with A ≤ N. The modulus sum over the cycle is 64·N + A.
- R2: `vco_pulse` is high for exactly the one clock that follows the `pre_en` step completing the N-th main count.
- R3: Select codes set the reference ratio: 3'b001 → 3168, 3'b010 → 2640, 3'b011 → 2112, 3'b100 → 3312, 3'b101 → 2760, 3'b110 → 2208. `ref_pulse` is high for the one clock after every ratio-th `ref_en`.
- R4: Select code 3'b000 uses ratio 3168 when the loaded transmit select is 1 and 2112 when it is 0.
- R5: Select code 3'b111 raises `disabled`. While it stays active, `ref_pulse`, `vco_pulse` and `mod_ctl` remain 0 and both counters stay at zero.
- R6: `load` captures N, A, code and transmit select into a shadow copy, and a later load replaces an earlier one. The shadow copy becomes active at the clock of the step that completes the current main count, or at the next clock if the channel is disabled. Both counters restart from zero on that clock, and no reference pulse comes from it.
- R7: After reset the channel is disabled, with all pulse outputs and `mod_ctl` low.
- R8: With N = 457 and A = 20, one divided cycle sums to 29268 VCO periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One reference-clock cycle has elapsed |
| pre_en | input | 1 | One prescaler output period has elapsed |
| load | input | 1 | Capture the programming inputs |
| n_in | input | 10 | Main count N |
| a_in | input | 6 | Swallow count A |
| sel_in | input | 3 | Reference-select code |
| tx_in | input | 1 | Transmit (1) or receive (0) select, used by code 3'b000 |
| ref_pulse | output | 1 | Comparison-frequency pulse |
| vco_pulse | output | 1 | Divided VCO pulse |
| mod_ctl | output | 1 | Prescaler modulus control, 1 = divide-by-65 |
| disabled | output | 1 | Channel is switched off |

## Verification
`ref_pulse` and `vco_pulse` appear one clock after the enable that completes a count. `mod_ctl` and `disabled` take their new values in the same clock that updates the step counter or the active settings. A load never shows at the outputs before the boundary clock. The bench changes inputs at the falling edge and advances its own counter model using the state from before the rising edge. It compares all four outputs at the following falling edge. The modulus sum is built from the `mod_ctl` values observed on each step and checked when the model's cycle completes.

// File: rtl/psd_pkg.sv
package psd_pkg;

  localparam int SEL_W   = 3;
  localparam int REF_MAX = 3312;
  localparam int REF_W   = $clog2(REF_MAX + 1);

  localparam logic [SEL_W-1:0] SEL_OFF  = 3'b111;
  localparam logic [SEL_W-1:0] SEL_DUAL = 3'b000;

  // reference ratio for a select code; zero means no ratio (channel off)
  function automatic logic [REF_W-1:0] ref_ratio(input logic [SEL_W-1:0] sel,
                                                 input logic tx);
    logic [REF_W-1:0] r;
    case (sel)
      SEL_DUAL: r = tx ? REF_W'(3168) : REF_W'(2112);
      3'b001:   r = REF_W'(3168);
      3'b010:   r = REF_W'(2640);
      3'b011:   r = REF_W'(2112);
      3'b100:   r = REF_W'(3312);
      3'b101:   r = REF_W'(2760);
      3'b110:   r = REF_W'(2208);
      default:  r = '0;
    endcase
    return r;
  endfunction

  function automatic logic sel_is_off(input logic [SEL_W-1:0] sel);
    return sel == SEL_OFF;
  endfunction

endpackage

// File: rtl/psd_cfg_hold.sv
module psd_cfg_hold
  import psd_pkg::*;
#(
  parameter int NW = 10,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NW-1:0]    n_in,
  input  logic [AW-1:0]    a_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             tx_in,
  input  logic             apply,
  output logic [NW-1:0]    act_n,
  output logic [AW-1:0]    act_a,
  output logic [SEL_W-1:0] act_sel,
  output logic             act_tx,
  output logic             pending
);

  logic [NW-1:0]    sh_n;
  logic [AW-1:0]    sh_a;
  logic [SEL_W-1:0] sh_sel;
  logic             sh_tx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_n    <= '0;
      sh_a    <= '0;
      sh_sel  <= SEL_OFF;
      sh_tx   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (load) begin
        sh_n   <= n_in;
        sh_a   <= a_in;
        sh_sel <= sel_in;
        sh_tx  <= tx_in;
      end
      pending <= load | (pending & ~apply);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_n   <= '0;
      act_a   <= '0;
      act_sel <= SEL_OFF;
      act_tx  <= 1'b0;
    end else if (apply) begin
      act_n   <= sh_n;
      act_a   <= sh_a;
      act_sel <= sh_sel;
      act_tx  <= sh_tx;
    end
  end

endmodule

// File: rtl/psd_ref_div.sv
module psd_ref_div
  import psd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [REF_W-1:0] ratio,
  output logic             pulse,
  output logic [REF_W-1:0] cnt
);

  logic last;
  assign last = (cnt >= ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (restart || !run) begin
        cnt <= '0;
      end else if (tick) begin
        if (last) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/psd_swallow_cnt.sv
module psd_swallow_cnt #(
  parameter int NW = 10,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [NW-1:0] n,
  input  logic [AW-1:0] a,
  output logic [NW-1:0] step,
  output logic          wrap,
  output logic          vco_pulse,
  output logic          mod_ctl
);

  logic [NW-1:0] last_step;
  logic          in_swallow;

  assign last_step  = n - 1'b1;
  assign wrap       = tick && run && (step == last_step);
  assign in_swallow = step < NW'(a);
  assign mod_ctl    = run && in_swallow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      vco_pulse <= 1'b0;
    end else begin
      vco_pulse <= wrap;
      if (restart || !run) begin
        step <= '0;
      end else if (tick) begin
        step <= wrap ? '0 : step + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pll_swallow_prog.sv
module pll_swallow_prog
  import psd_pkg::*;
#(
  parameter int NW = 10,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             pre_en,
  input  logic             load,
  input  logic [NW-1:0]    n_in,
  input  logic [AW-1:0]    a_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             tx_in,
  output logic             ref_pulse,
  output logic             vco_pulse,
  output logic             mod_ctl,
  output logic             disabled
);

  logic [NW-1:0]    act_n;
  logic [AW-1:0]    act_a;
  logic [SEL_W-1:0] act_sel;
  logic             act_tx;
  logic             pending;
  logic             chan_off;
  logic             wrap_evt;
  logic             apply_evt;
  logic [REF_W-1:0] ratio_sel;
  logic [REF_W-1:0] ref_cnt_q;
  logic [NW-1:0]    step_q;

  assign chan_off  = sel_is_off(act_sel);
  assign ratio_sel = ref_ratio(act_sel, act_tx);
  assign apply_evt = pending && (chan_off || wrap_evt);
  assign disabled  = chan_off;

  psd_cfg_hold #(.NW(NW), .AW(AW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .n_in    (n_in),
    .a_in    (a_in),
    .sel_in  (sel_in),
    .tx_in   (tx_in),
    .apply   (apply_evt),
    .act_n   (act_n),
    .act_a   (act_a),
    .act_sel (act_sel),
    .act_tx  (act_tx),
    .pending (pending)
  );

  psd_ref_div u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ref_en),
    .run     (!chan_off),
    .restart (apply_evt),
    .ratio   (ratio_sel),
    .pulse   (ref_pulse),
    .cnt     (ref_cnt_q)
  );

  psd_swallow_cnt #(.NW(NW), .AW(AW)) u_swl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (pre_en),
    .run       (!chan_off),
    .restart   (apply_evt),
    .n         (act_n),
    .a         (act_a),
    .step      (step_q),
    .wrap      (wrap_evt),
    .vco_pulse (vco_pulse),
    .mod_ctl   (mod_ctl)
  );

endmodule

// File: rtl/psd_checker.sv
module psd_checker
  import psd_pkg::*;
#(
  parameter int NW = 10,
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pre_en,
  input logic             ref_pulse,
  input logic             vco_pulse,
  input logic             mod_ctl,
  input logic             disabled,
  input logic             apply_evt,
  input logic [NW-1:0]    step_q,
  input logic [REF_W-1:0] ref_cnt_q,
  input logic [NW-1:0]    act_n,
  input logic [AW-1:0]    act_a,
  input logic [SEL_W-1:0] act_sel,
  input logic             act_tx
);

  // R5: an off channel that stays off is silent
  p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (disabled && $past(disabled)) |-> (!ref_pulse && !vco_pulse && !mod_ctl));

  // R2: a divided pulse always follows a prescaler step
  p_vco_needs_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vco_pulse |-> $past(pre_en));

  // R6: settings change only on an apply event
  p_cfg_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_evt |=> $stable({act_n, act_a, act_sel, act_tx}));

  // R3: reference count stays inside the active ratio
  p_ref_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !disabled |-> (ref_cnt_q < ref_ratio(act_sel, act_tx)));

  // R1: main step stays below N
  p_step_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!disabled && act_n != '0) |-> (step_q < act_n));

  // R1: swallow phase ends exactly when A steps have been counted
  p_mod_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_ctl) && !disabled && !$past(apply_evt)) |-> (step_q == NW'(act_a)));

endmodule

bind pll_swallow_prog psd_checker #(.NW(NW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pre_en    (pre_en),
  .ref_pulse (ref_pulse),
  .vco_pulse (vco_pulse),
  .mod_ctl   (mod_ctl),
  .disabled  (disabled),
  .apply_evt (apply_evt),
  .step_q    (step_q),
  .ref_cnt_q (ref_cnt_q),
  .act_n     (act_n),
  .act_a     (act_a),
  .act_sel   (act_sel),
  .act_tx    (act_tx)
);

// File: tb/pll_swallow_prog_tb.sv
module pll_swallow_prog_tb;

  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_en, pre_en, load, tx_in;
  logic [9:0] n_in;
  logic [5:0] a_in;
  logic [2:0] sel_in;
  logic ref_pulse, vco_pulse, mod_ctl, disabled;

  always #(CLK_NS/2) clk = ~clk;

  pll_swallow_prog u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .pre_en(pre_en), .load(load),
    .n_in(n_in), .a_in(a_in), .sel_in(sel_in), .tx_in(tx_in),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse), .mod_ctl(mod_ctl),
    .disabled(disabled)
  );

  int checks = 0;
  int fails  = 0;

  // bench model state
  int m_n, m_a, m_sel; bit m_tx;
  int s_n, s_a, s_sel; bit s_tx;
  bit m_pend;
  int m_step, m_rcnt, acc;
  bit exp_ref, exp_vco;
  int ref_seen;

  function automatic int want_ratio(input int sel, input bit tx);
    int t;
    if (sel == 0)      t = tx ? 3168 : 2112;
    else if (sel == 1) t = 3168;
    else if (sel == 2) t = 2640;
    else if (sel == 3) t = 2112;
    else if (sel == 4) t = 3312;
    else if (sel == 5) t = 2760;
    else if (sel == 6) t = 2208;
    else               t = 0;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit re, input bit pe, input bit ld,
                     input int n, input int a, input int sel, input bit tx);
    bit mod_seen, off_old, wrap, app;
    int ratio;
    mod_seen = mod_ctl;
    ref_en = re; pre_en = pe; load = ld;
    n_in = 10'(n); a_in = 6'(a); sel_in = 3'(sel); tx_in = tx;
    @(posedge clk);
    off_old = (m_sel == 7);
    ratio   = want_ratio(m_sel, m_tx);
    wrap    = pe && !off_old && (m_step == ((m_n + 1023) % 1024));
    app     = m_pend && (off_old || wrap);
    exp_vco = wrap;
    exp_ref = re && !off_old && !app && (m_rcnt == ratio - 1);
    if (pe && !off_old) begin
      acc += 64 + int'(mod_seen);
      if (wrap) begin
        check(acc == 64 * m_n + m_a, "R1 modulus sum", acc, 64 * m_n + m_a);
        if (m_n == 457 && m_a == 20)
          check(acc == 29268, "R8 division 457/20", acc, 29268);
        acc = 0;
      end
    end
    if (app || off_old) begin
      m_step = 0; m_rcnt = 0; acc = 0;
    end else begin
      if (pe) m_step = wrap ? 0 : m_step + 1;
      if (re) m_rcnt = (m_rcnt == ratio - 1) ? 0 : m_rcnt + 1;
    end
    if (app) begin m_n = s_n; m_a = s_a; m_sel = s_sel; m_tx = s_tx; end
    if (ld)  begin s_n = n; s_a = a; s_sel = sel; s_tx = tx; end
    m_pend = ld | (m_pend & !app);
    @(negedge clk);
    if (ref_pulse) ref_seen++;
    check(disabled == (m_sel == 7), "R5 disabled flag", int'(disabled), int'(m_sel == 7));
    check(mod_ctl == (m_sel != 7 && m_step < m_a), "R1 mod_ctl", int'(mod_ctl),
          int'(m_sel != 7 && m_step < m_a));
    check(vco_pulse == exp_vco, "R2 vco_pulse", int'(vco_pulse), int'(exp_vco));
    check(ref_pulse == exp_ref, (m_sel == 0) ? "R4 ref_pulse" : "R3 ref_pulse",
          int'(ref_pulse), int'(exp_ref));
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; ref_en = 0; pre_en = 0; load = 0;
    n_in = 0; a_in = 0; sel_in = 0; tx_in = 0;
    m_n = 0; m_a = 0; m_sel = 7; m_tx = 0;
    s_n = 0; s_a = 0; s_sel = 7; s_tx = 0;
    m_pend = 0; m_step = 0; m_rcnt = 0; acc = 0; ref_seen = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    check(disabled == 1'b1, "R7 reset disabled", int'(disabled), 1);
    check(!ref_pulse && !vco_pulse && !mod_ctl, "R7 reset outputs",
          int'({ref_pulse, vco_pulse, mod_ctl}), 0);

    // R8 and R1: directed 457/20 with continuous prescaler steps
    cyc(1, 1, 1, 457, 20, 2, 0);
    for (int i = 0; i < 2 * 457 + 20; i++) cyc(0, 1, 0, 0, 0, 0, 0);

    // R1 edge: A equal to N, and A zero
    cyc(0, 1, 1, 7, 7, 3, 0);
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 9, 0, 3, 0);
    for (int i = 0; i < 40; i++) cyc(0, 1, 0, 0, 0, 0, 0);

    // R3/R4: every ratio code, reference running every clock
    for (int code = 0; code < 8; code++) begin
      bit tx = (code == 7);
      int sel = (code == 7) ? 0 : code;
      ref_seen = 0;
      cyc(1, 1, 1, 5, 2, sel, tx);
      for (int i = 0; i < 7000; i++) cyc(1, 1, 0, 0, 0, 0, 0);
      if (sel == 0) check(ref_seen >= 2, "R4 pulses seen", ref_seen, 2);
      else          check(ref_seen >= 2, "R3 pulses seen", ref_seen, 2);
    end

    // R5: channel off, everything held
    cyc(1, 1, 1, 5, 2, 7, 0);
    for (int i = 0; i < 400; i++) cyc(1, 1, 0, 0, 0, 0, 0);
    check(disabled == 1'b1, "R5 stays off", int'(disabled), 1);

    // R6: from off, a load applies on the next clock
    cyc(0, 0, 1, 40, 3, 2, 0);
    check(disabled == 1'b1, "R6 not before boundary", int'(disabled), 1);
    cyc(0, 0, 0, 0, 0, 0, 0);
    check(disabled == 1'b0, "R6 applied when off", int'(disabled), 0);
    // R6: mid-cycle loads wait for the wrap; the later load wins
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 12, 1, 7, 0);
    cyc(0, 0, 1, 12, 4, 5, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    check(disabled == 1'b0, "R6 held until boundary", int'(disabled), 0);
    check(mod_ctl == 1'b0, "R6 old A kept", int'(mod_ctl), 0);
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0, 0, 0, 0);
    check(disabled == 1'b0, "R6 later load wins", int'(disabled), 0);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      bit ld = ($urandom % 150) == 0;
      int n  = 1 + ($urandom % 40);
      int a  = $urandom % (n + 1);
      cyc(bit'($urandom % 2), bit'($urandom % 2), ld, n, a,
          int'($urandom % 8), bit'($urandom % 2));
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule